// File: doc/BRIEF.md
# Dual-Mode Wide / Split Integer Multiplier

The block multiplies two operands taken from the low half of two 32-bit input words. It has two modes. In wide mode it forms a single 16x16 product with a 32-bit result. In split mode it forms two independent 8x8 products and packs the two 16-bit results into one 32-bit word. A signedness control selects two's-complement or unsigned interpretation of the operands. Both modes are built from the same four byte-lane partial multipliers.

A producer presents operands with `valid_i` high. The product is captured on that clock edge and appears on `result_o` with `valid_o` one cycle later. While `valid_i` is low, the last captured result stays on `result_o`. This lets a datapath issue one multiply per cycle in either mode without stalling.

Top module: `dual_mul`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `result_o` is 0.
- R2: With `split_i`=0 (wide mode) and `signed_i`=0, `result_o` is the unsigned product of `a_i[15:0]` and `b_i[15:0]` over its full 32 bits.
- R3: With `split_i`=0 and `signed_i`=1, `result_o` is the 32-bit two's-complement product of `a_i[15:0]` and `b_i[15:0]`, each read as a signed 16-bit value.
- R4: With `split_i`=1 and `signed_i`=0, `result_o[15:0]` is the unsigned product of `a_i[7:0]` and `b_i[7:0]`, and `result_o[31:16]` is the unsigned product of `a_i[15:8]` and `b_i[15:8]`. Neither lane affects the other.
- R5: With `split_i`=1 and `signed_i`=1, each byte is read as a signed 8-bit value. Each lane result is the 16-bit two's-complement product, placed in the same halves as in R4.
- R6: Bits 31:16 of `a_i` and `b_i` have no effect on `result_o` in either mode.
- R7: When `valid_i` is high at a rising clock edge, the result for those operands is on `result_o` after that edge and `valid_o` is 1 until the next edge. When `valid_i` is low at the edge, `valid_o` is 0 after it.
- R8: When `valid_i` is low at a rising edge, `result_o` keeps its previous value across that edge.
- R9: In signed wide mode, a product of two nonzero operands of opposite sign sets `result_o[31]`. The extreme cases come out exactly: -32768 x -32768 gives 0x40000000, and -32768 x 32767 gives 0xC0008000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands valid; capture the product at this edge |
| split_i | input | 1 | 0: one 16x16 product; 1: two packed 8x8 products |
| signed_i | input | 1 | 1: operands are two's complement; 0: unsigned |
| a_i | input | 32 | First operand word; only bits 15:0 are used |
| b_i | input | 32 | Second operand word; only bits 15:0 are used |
| valid_o | output | 1 | Result valid, one cycle after `valid_i` |
| result_o | output | 32 | Product, or the two packed lane products |

## Verification
Every product is due exactly one rising edge after the cycle that presents it with `valid_i` high, and `valid_o` follows the same one-edge delay. The bench changes inputs on the falling edge. On the next falling edge, which is half a cycle after the capturing edge, it compares both outputs against a behavioural model. That model computes the expected word with 64-bit integer arithmetic when the stimulus is applied. Cycles with `valid_i` low check that the previous expected word is held. Directed corner cases cover extreme signed values, opposite-sign lanes and garbage in the ignored upper bits. A long random run then mixes all four mode combinations with idle cycles.

// File: rtl/dual_mul_pkg.sv
package dual_mul_pkg;
  localparam int unsigned LANE_COUNT = 4;

  typedef enum logic {
    MODE_WIDE  = 1'b0,
    MODE_SPLIT = 1'b1
  } mul_mode_e;
endpackage

// File: rtl/dual_mul_prep.sv
// Splits the low half of each operand word into two byte lanes with an extension bit.
module dual_mul_prep #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 8
) (
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  dual_mul_pkg::mul_mode_e mode_i,
  input  logic                signed_i,
  output logic [LANE_W:0]     a_lo_o,
  output logic [LANE_W:0]     a_hi_o,
  output logic [LANE_W:0]     b_lo_o,
  output logic [LANE_W:0]     b_hi_o
);
  import dual_mul_pkg::*;

  logic lo_ext_en;
  // low bytes carry sign only when they are standalone split-mode operands
  assign lo_ext_en = signed_i && (mode_i == MODE_SPLIT);

  always_comb begin
    a_lo_o = {lo_ext_en & a_i[LANE_W-1], a_i[LANE_W-1:0]};
    b_lo_o = {lo_ext_en & b_i[LANE_W-1], b_i[LANE_W-1:0]};
    a_hi_o = {signed_i & a_i[2*LANE_W-1], a_i[2*LANE_W-1:LANE_W]};
    b_hi_o = {signed_i & b_i[2*LANE_W-1], b_i[2*LANE_W-1:LANE_W]};
  end
endmodule

// File: rtl/dual_mul_lane.sv
// One (LANE_W+1)x(LANE_W+1) two's-complement partial multiplier.
module dual_mul_lane #(
  parameter int unsigned LANE_W = 8
) (
  input  logic [LANE_W:0]       x_i,
  input  logic [LANE_W:0]       y_i,
  output logic [2*LANE_W+1:0]   p_o
);
  localparam int unsigned OPW = LANE_W + 1;
  localparam int unsigned PW  = 2 * OPW;

  logic [PW-1:0] x_ext, y_ext;
  assign x_ext = {{OPW{x_i[LANE_W]}}, x_i};
  assign y_ext = {{OPW{y_i[LANE_W]}}, y_i};
  // low PW bits of the extended unsigned product equal the signed product
  assign p_o = x_ext * y_ext;
endmodule

// File: rtl/dual_mul_combine.sv
// Merges lane products into either one wide product or two packed lane results.
module dual_mul_combine #(
  parameter int unsigned LANE_W = 8
) (
  input  dual_mul_pkg::mul_mode_e mode_i,
  input  logic [2*LANE_W+1:0]     pp_ll_i,
  input  logic [2*LANE_W+1:0]     pp_lh_i,
  input  logic [2*LANE_W+1:0]     pp_hl_i,
  input  logic [2*LANE_W+1:0]     pp_hh_i,
  output logic [4*LANE_W-1:0]     prod_o
);
  import dual_mul_pkg::*;

  localparam int unsigned PW    = 2 * LANE_W + 2;
  localparam int unsigned RES_W = 4 * LANE_W;
  localparam int unsigned PAD   = RES_W - PW;

  logic [RES_W-1:0] ll_x, lh_x, hl_x, hh_x, wide_sum, split_pack;

  assign ll_x = {{PAD{pp_ll_i[PW-1]}}, pp_ll_i};
  assign lh_x = {{PAD{pp_lh_i[PW-1]}}, pp_lh_i};
  assign hl_x = {{PAD{pp_hl_i[PW-1]}}, pp_hl_i};
  assign hh_x = {{PAD{pp_hh_i[PW-1]}}, pp_hh_i};

  // modulo-2^RES_W sum is exact for a RES_W-bit product
  assign wide_sum   = (hh_x << (2*LANE_W)) + (lh_x << LANE_W) + (hl_x << LANE_W) + ll_x;
  assign split_pack = {pp_hh_i[2*LANE_W-1:0], pp_ll_i[2*LANE_W-1:0]};

  assign prod_o = (mode_i == MODE_SPLIT) ? split_pack : wide_sum;
endmodule

// File: rtl/dual_mul_oreg.sv
module dual_mul_oreg #(
  parameter int unsigned RES_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [RES_W-1:0] prod_i,
  output logic             valid_o,
  output logic [RES_W-1:0] result_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= prod_i;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R7
  AST_VALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)); // R8
  always_comb begin
    if (!rst_ni) AST_RESET_CLEAR: assert (!valid_o && result_o == '0); // R1
  end
endmodule

// File: rtl/dual_mul.sv
module dual_mul #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              split_i,
  input  logic              signed_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  import dual_mul_pkg::*;

  localparam int unsigned WIDE_W = 2 * LANE_W;
  localparam int unsigned RES_W  = 2 * WIDE_W;
  localparam int unsigned PW     = 2 * LANE_W + 2;

  mul_mode_e mode;
  assign mode = split_i ? MODE_SPLIT : MODE_WIDE;

  logic [LANE_W:0] a_half [2];
  logic [LANE_W:0] b_half [2];
  logic [PW-1:0]   pp [LANE_COUNT];
  logic [RES_W-1:0] prod;
  logic [RES_W-1:0] res_q;

  dual_mul_prep #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_prep (
    .a_i(a_i), .b_i(b_i), .mode_i(mode), .signed_i(signed_i),
    .a_lo_o(a_half[0]), .a_hi_o(a_half[1]),
    .b_lo_o(b_half[0]), .b_hi_o(b_half[1])
  );

  // lane index bit 1 picks the a half, bit 0 the b half
  for (genvar g = 0; g < LANE_COUNT; g++) begin : g_lane
    dual_mul_lane #(.LANE_W(LANE_W)) u_lane (
      .x_i(a_half[g/2]), .y_i(b_half[g%2]), .p_o(pp[g])
    );
  end

  dual_mul_combine #(.LANE_W(LANE_W)) u_comb (
    .mode_i(mode),
    .pp_ll_i(pp[0]), .pp_lh_i(pp[1]), .pp_hl_i(pp[2]), .pp_hh_i(pp[3]),
    .prod_o(prod)
  );

  dual_mul_oreg #(.RES_W(RES_W)) u_oreg (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .prod_i(prod), .valid_o(valid_o), .result_o(res_q)
  );

  if (DATA_W > RES_W) begin : g_pad
    assign result_o = {{(DATA_W-RES_W){1'b0}}, res_q};
  end else begin : g_nopad
    assign result_o = res_q[DATA_W-1:0];
  end

  AST_WIDE_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !split_i && signed_i && (a_i[WIDE_W-1] != b_i[WIDE_W-1])
     && (a_i[WIDE_W-1:0] != '0) && (b_i[WIDE_W-1:0] != '0)) |=> res_q[RES_W-1]); // R9
  AST_WIDE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !split_i && (a_i[WIDE_W-1:0] == '0)) |=> (res_q == '0)); // R2
  AST_SPLIT_LO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && split_i && (a_i[LANE_W-1:0] == '0)) |=> (res_q[WIDE_W-1:0] == '0)); // R4
  AST_SPLIT_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && split_i && (b_i[WIDE_W-1:LANE_W] == '0)) |=> (res_q[RES_W-1:WIDE_W] == '0)); // R5
endmodule

// File: tb/dual_mul_tb_top.sv
`timescale 1ns/1ps
module dual_mul_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        split_i = 1'b0;
  logic        signed_i = 1'b0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic        valid_o;
  logic [31:0] result_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] exp_result = '0;
  logic        exp_valid = 1'b0;
  string       exp_tag = "R1";

  always #4 clk_i = ~clk_i;

  dual_mul dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .split_i(split_i),
    .signed_i(signed_i), .a_i(a_i), .b_i(b_i),
    .valid_o(valid_o), .result_o(result_o)
  );

  function automatic longint val_of(logic [15:0] v, int w, bit sg);
    longint r;
    r = (w == 16) ? longint'(v) : longint'(v[7:0]);
    if (sg && v[w-1]) r = r - (longint'(1) << w);
    return r;
  endfunction

  function automatic logic [31:0] model(bit sp, bit sg, logic [31:0] a, logic [31:0] b);
    longint p, q;
    logic [63:0] pw, qw;
    if (!sp) begin
      p = val_of(a[15:0], 16, sg) * val_of(b[15:0], 16, sg);
      pw = 64'(p);
      return pw[31:0];
    end
    p = val_of({8'h0, a[7:0]}, 8, sg) * val_of({8'h0, b[7:0]}, 8, sg);
    q = val_of({8'h0, a[15:8]}, 8, sg) * val_of({8'h0, b[15:8]}, 8, sg);
    pw = 64'(p);
    qw = 64'(q);
    return {qw[15:0], pw[15:0]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at negedge: compare, then drive the next input
  task automatic step(bit v, bit sp, bit sg, logic [31:0] a, logic [31:0] b, string tag);
    @(negedge clk_i);
    check({exp_tag, " R7 valid"}, {31'b0, valid_o}, {31'b0, exp_valid});
    check(exp_tag, result_o, exp_result);
    valid_i = v; split_i = sp; signed_i = sg; a_i = a; b_i = b;
    exp_valid = v;
    if (v) begin
      exp_result = model(sp, sg, a, b);
      exp_tag = tag;
    end else begin
      exp_tag = "R8 hold";
    end
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    // R1 reset
    #3;
    check("R1 reset valid", {31'b0, valid_o}, 32'h0);
    check("R1 reset result", result_o, 32'h0);
    a_i = 32'hFFFF_FFFF; b_i = 32'hFFFF_FFFF; valid_i = 1'b1;
    repeat (2) @(posedge clk_i);
    #1;
    check("R1 reset held valid", {31'b0, valid_o}, 32'h0);
    check("R1 reset held result", result_o, 32'h0);
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni = 1'b1;

    step(1, 0, 0, 32'h0000_FFFF, 32'h0000_FFFF, "R2 wide unsigned max");
    step(1, 0, 0, 32'h0000_1234, 32'h0000_5678, "R2 wide unsigned");
    step(1, 0, 1, 32'h0000_FFFF, 32'h0000_FFFF, "R3 wide signed -1*-1");
    step(1, 0, 1, 32'h0000_8000, 32'h0000_8000, "R9 -32768*-32768");
    @(negedge clk_i);
    check("R9 extreme value", result_o, 32'h4000_0000);
    check("R7 valid", {31'b0, valid_o}, 32'h1);
    valid_i = 1'b1; split_i = 1'b0; signed_i = 1'b1; a_i = 32'h0000_8000; b_i = 32'h0000_7FFF;
    exp_result = model(0, 1, a_i, b_i); exp_valid = 1'b1; exp_tag = "R9 -32768*32767";
    @(negedge clk_i);
    check("R9 extreme neg", result_o, 32'hC000_8000);
    check("R9 sign bit", {31'b0, result_o[31]}, 32'h1);
    valid_i = 1'b0; exp_valid = 1'b0; exp_tag = "R8 hold";
    step(1, 0, 1, 32'h0000_FFFE, 32'h0000_0003, "R9 -2*3");
    step(1, 1, 0, 32'h0000_FF02, 32'h0000_FF03, "R4 split unsigned");
    step(1, 1, 0, 32'h0000_00FF, 32'h0000_FFFF, "R4 lane isolation");
    step(1, 1, 1, 32'h0000_80FF, 32'h0000_8001, "R5 split signed");
    step(1, 1, 1, 32'h0000_7F80, 32'h0000_8080, "R5 split signed extremes");
    step(1, 0, 0, 32'hDEAD_0003, 32'hBEEF_0005, "R6 upper ignored wide");
    step(1, 1, 1, 32'hA5A5_F00F, 32'h5A5A_0FF0, "R6 upper ignored split");
    step(1, 0, 1, 32'hFFFF_0000, 32'hFFFF_1234, "R6 upper ignored zero");
    step(0, 0, 0, 32'h0000_1111, 32'h0000_2222, "");
    step(0, 1, 1, 32'h0000_3333, 32'h0000_4444, "");
    step(1, 0, 0, 32'h0000_0002, 32'h0000_0002, "R7 after idle");

    for (int i = 0; i < 4000; i++) begin
      bit v, sp, sg;
      string t;
      v = ($urandom % 4) != 0;
      sp = $urandom % 2;
      sg = $urandom % 2;
      t = sp ? (sg ? "R5 rand" : "R4 rand") : (sg ? "R3 rand" : "R2 rand");
      step(v, sp, sg, $urandom, $urandom, t);
    end
    step(0, 0, 0, 32'h0, 32'h0, "");
    @(negedge clk_i);
    check({exp_tag, " R7 valid"}, {31'b0, valid_o}, {31'b0, exp_valid});
    check(exp_tag, result_o, exp_result);
    finish_run();
  end
endmodule